// File: doc/BRIEF.md
# Parallel Port Line Receiver

This block is the receive side of a clocked parallel data port. On every clock while the receiver is enabled it takes in one word from a data bus of 8 to 16 lines, together with a line-start marker. It masks off the data lines that are not in use and works out whether the word opens a new line. It then hands the word and its first-of-line flag to an internal consumer over a valid/ready stream.

The eight low lines are always in use. Between zero and eight further upper lines can be switched on, which gives any word width from 8 to 16 bits. The line-start marker can be read as active-high or active-low, or it can be ignored. When it is ignored, a programmable line length produces the first-of-line flags internally.

The port has no flow control of its own, so a small FIFO sits between the port side and the stream. Back-pressure rules: the stream holds a word and its flag steady for as long as `m_valid` is high and `m_ready` is low. A word is taken on a clock edge where both are high. If the FIFO is full when a new port word arrives, that word is dropped and a sticky overflow flag is raised. The line counter still advances past the dropped word.

Top module: `ppr_line_rx`

## Requirements
- R1: While `rst_n` is low, `m_valid`, `line_err` and `rx_ovf` are 0.
- R2: Data bits 0..7 pass unchanged. Upper bit 8+i is kept only when i < `cfg_hi_lines`; every other upper bit is delivered as 0. Values of `cfg_hi_lines` above 8 act as 8.
- R3: With `cfg_start_off`=0, the marker is active when `pin_start` XOR `cfg_start_inv` is 1 (active-high when `cfg_start_inv`=0). A word's `m_first` equals that active state in the cycle the word was sampled.
- R4: With `cfg_start_off`=1, `pin_start` has no effect. `m_first` is 1 on the first word sampled after enable and then on every `cfg_line_len`-th word (a length of 0 or 1 marks every word).
- R5: With the marker in use, a marker on a word that is not at a line boundary starts a new line: that word is flagged first and the count restarts from it. It also sets `line_err`, which then stays 1 while `cfg_en` stays 1.
- R6: With the marker in use, words sampled before the first marker, and words after a completed line of `cfg_line_len` words, are not flagged and raise no error. A marker at a line boundary raises no error.
- R7: While `m_valid`=1 and `m_ready`=0, `m_valid`, `m_data` and `m_first` hold their values. Words leave in the order they were sampled.
- R8: A word that arrives while the FIFO holds `DEPTH` words is dropped and sets `rx_ovf`, which stays 1 while `cfg_en` stays 1. The line counter still counts the dropped word.
- R9: Into an empty FIFO, a word present on the pins at clock edge t appears on `m_valid`/`m_data` just after edge t+1.
- R10: While `cfg_en` is 0, no word is sampled. On the edge after `cfg_en` is seen low, the line counter, `line_err` and `rx_ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Receiver enable |
| cfg_hi_lines | input | 4 | Number of upper data lines in use (0..8) |
| cfg_start_inv | input | 1 | Invert line-start marker polarity |
| cfg_start_off | input | 1 | Ignore line-start marker; counter generates line starts |
| cfg_line_len | input | 12 | Words per line |
| pin_data | input | 16 | Port data lines |
| pin_start | input | 1 | Port line-start marker |
| m_valid | output | 1 | Stream word valid |
| m_ready | input | 1 | Stream consumer ready |
| m_data | output | 16 | Stream word, unused upper bits zero |
| m_first | output | 1 | Word opens a line |
| line_err | output | 1 | Sticky: marker seen in mid-line |
| rx_ovf | output | 1 | Sticky: word dropped on full FIFO |

## Verification
A line counter that is off by even one position shows up at the ports in two ways: `m_first` lands on the wrong word, and with the marker in use `line_err` rises on the next marker. Both appear two edges after the offending word is sampled. A wrong mask or a polarity slip corrupts the very next delivered word. A wrong FIFO count shows first as `m_valid` disagreeing with the model, or as `rx_ovf` rising early or late under back-pressure. The bench compares every output against its model on every clock, so any divergence is reported in the cycle it first becomes visible.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  localparam int BASE_W = 8;
  localparam int EXT_W  = 8;
  localparam int DW     = BASE_W + EXT_W;
  localparam int HI_W   = $clog2(EXT_W + 1);

  typedef struct packed {
    logic          first;
    logic [DW-1:0] data;
  } word_t;

  localparam int WORD_W = $bits(word_t);
endpackage

// File: rtl/ppr_capture.sv
module ppr_capture
  import ppr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] pin_data,
  input  logic          pin_start,
  output logic          s_vld,
  output logic [DW-1:0] s_data,
  output logic          s_start
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_vld   <= 1'b0;
      s_data  <= '0;
      s_start <= 1'b0;
    end else begin
      s_vld   <= en;
      s_data  <= pin_data;
      s_start <= pin_start;
    end
  end
endmodule

// File: rtl/ppr_frame.sv
module ppr_frame
  import ppr_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [HI_W-1:0]  cfg_hi_lines,
  input  logic             cfg_start_inv,
  input  logic             cfg_start_off,
  input  logic [LEN_W-1:0] cfg_line_len,
  input  logic             s_vld,
  input  logic [DW-1:0]    s_data,
  input  logic             s_start,
  input  logic             fifo_full,
  output logic             push,
  output word_t            push_word,
  output logic             line_err,
  output logic             rx_ovf
);
  logic [HI_W-1:0]  hi_eff;
  logic [DW-1:0]    keep;
  logic             mark;
  logic             first;
  logic             take;
  logic [LEN_W-1:0] pos, pos_nxt;
  logic [LEN_W:0]   pos_inc;
  logic [LEN_W:0]   one_w;

  assign hi_eff = (cfg_hi_lines > HI_W'(EXT_W)) ? HI_W'(EXT_W) : cfg_hi_lines;

  genvar gi;
  generate
    for (gi = 0; gi < BASE_W; gi++) begin : g_base
      assign keep[gi] = 1'b1;
    end
    for (gi = 0; gi < EXT_W; gi++) begin : g_ext
      assign keep[BASE_W+gi] = (HI_W'(gi) < hi_eff);
    end
  endgenerate

  assign take  = s_vld && cfg_en;
  assign mark  = !cfg_start_off && (s_start ^ cfg_start_inv);
  assign first = cfg_start_off ? (pos == '0) : mark;
  assign one_w = {{LEN_W{1'b0}}, 1'b1};
  assign pos_inc = {1'b0, pos} + one_w;

  always_comb begin
    pos_nxt = pos;
    if (first) begin
      pos_nxt = (one_w >= {1'b0, cfg_line_len}) ? '0 : LEN_W'(1);
    end else if (pos != '0) begin
      pos_nxt = (pos_inc >= {1'b0, cfg_line_len}) ? '0 : pos_inc[LEN_W-1:0];
    end
  end

  assign push            = take && !fifo_full;
  assign push_word.first = first;
  assign push_word.data  = s_data & keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '0;
      line_err <= 1'b0;
      rx_ovf   <= 1'b0;
    end else if (!cfg_en) begin
      pos      <= '0;
      line_err <= 1'b0;
      rx_ovf   <= 1'b0;
    end else if (s_vld) begin
      pos <= pos_nxt;
      if (mark && pos != '0) line_err <= 1'b1;
      if (fifo_full) rx_ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/ppr_fifo.sv
module ppr_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  output logic         full,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign full     = (cnt == CW'(DEPTH));
  assign rd_valid = (cnt != '0);
  assign rd_data  = mem[rp];
  assign do_wr    = wr && !full;
  assign do_rd    = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ppr_line_rx.sv
module ppr_line_rx
  import ppr_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [HI_W-1:0]  cfg_hi_lines,
  input  logic             cfg_start_inv,
  input  logic             cfg_start_off,
  input  logic [LEN_W-1:0] cfg_line_len,
  input  logic [DW-1:0]    pin_data,
  input  logic             pin_start,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [DW-1:0]    m_data,
  output logic             m_first,
  output logic             line_err,
  output logic             rx_ovf
);
  logic          s_vld, s_start;
  logic [DW-1:0] s_data;
  logic          push_w, full_w;
  word_t         push_word, head;
  logic [WORD_W-1:0] head_bits;

  ppr_capture u_cap (
    .clk(clk), .rst_n(rst_n), .en(cfg_en),
    .pin_data(pin_data), .pin_start(pin_start),
    .s_vld(s_vld), .s_data(s_data), .s_start(s_start)
  );

  ppr_frame #(.LEN_W(LEN_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
    .cfg_hi_lines(cfg_hi_lines), .cfg_start_inv(cfg_start_inv),
    .cfg_start_off(cfg_start_off), .cfg_line_len(cfg_line_len),
    .s_vld(s_vld), .s_data(s_data), .s_start(s_start),
    .fifo_full(full_w), .push(push_w), .push_word(push_word),
    .line_err(line_err), .rx_ovf(rx_ovf)
  );

  ppr_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr(push_w), .wr_data(push_word),
    .full(full_w), .rd_valid(m_valid), .rd_ready(m_ready), .rd_data(head_bits)
  );

  assign head    = word_t'(head_bits);
  assign m_data  = head.data;
  assign m_first = head.first;
endmodule

// File: rtl/ppr_line_rx_chk.sv
module ppr_line_rx_chk
  import ppr_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          m_valid,
  input logic          m_ready,
  input logic [DW-1:0] m_data,
  input logic          m_first,
  input logic          line_err,
  input logic          rx_ovf,
  input logic          push_w
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_first)));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_err && cfg_en) |=> line_err);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && cfg_en) |=> rx_ovf);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (!line_err && !rx_ovf));

  p_no_push_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> !push_w);
endmodule

bind ppr_line_rx ppr_line_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_first(m_first),
  .line_err(line_err), .rx_ovf(rx_ovf), .push_w(push_w)
);

// File: tb/tb_ppr_line_rx.sv
module tb_ppr_line_rx;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic [3:0]  cfg_hi_lines = 4'd0;
  logic        cfg_start_inv = 1'b0;
  logic        cfg_start_off = 1'b0;
  logic [11:0] cfg_line_len = 12'd5;
  logic [15:0] pin_data = 16'h0;
  logic        pin_start = 1'b0;
  logic        m_valid, m_ready = 1'b1, m_first, line_err, rx_ovf;
  logic [15:0] m_data;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  ppr_line_rx #(.LEN_W(12), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_hi_lines(cfg_hi_lines),
    .cfg_start_inv(cfg_start_inv), .cfg_start_off(cfg_start_off),
    .cfg_line_len(cfg_line_len), .pin_data(pin_data), .pin_start(pin_start),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_first(m_first),
    .line_err(line_err), .rx_ovf(rx_ovf)
  );

  always #4 clk = ~clk;

  // Reference model state
  int dq[$];
  bit fq[$];
  bit s1v, s1s;
  int s1d;
  int pos;
  bit merr, movf;

  always @(posedge clk) begin
    if (!rst_n) begin
      dq.delete(); fq.delete();
      s1v = 0; s1s = 0; s1d = 0; pos = 0; merr = 0; movf = 0;
    end else begin
      int  sz, w, len, npos;
      bit  act, fst;
      sz = dq.size();
      if (sz > 0 && m_ready) begin
        void'(dq.pop_front()); void'(fq.pop_front());
      end
      if (!cfg_en) begin
        pos = 0; merr = 0; movf = 0;
      end else if (s1v) begin
        w   = 8 + ((cfg_hi_lines > 8) ? 8 : int'(cfg_hi_lines));
        len = int'(cfg_line_len);
        act = !cfg_start_off && (s1s ^ cfg_start_inv);
        fst = cfg_start_off ? (pos == 0) : act;
        if (act && pos != 0) merr = 1;
        if (fst) npos = (1 >= len) ? 0 : 1;
        else if (pos != 0) npos = (pos + 1 >= len) ? 0 : pos + 1;
        else npos = 0;
        pos = npos;
        if (sz == DEPTH) movf = 1;
        else begin
          dq.push_back(s1d & ((1 << w) - 1));
          fq.push_back(fst);
        end
      end
      s1v = cfg_en; s1d = int'(pin_data); s1s = pin_start;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_valid === (dq.size() > 0), "R9/R7 m_valid", int'(m_valid), int'(dq.size() > 0));
      if (m_valid === 1'b1 && dq.size() > 0) begin
        chk(int'(m_data) == dq[0], "R2/R7 m_data", int'(m_data), dq[0]);
        chk(m_first === fq[0], "R3/R4/R5/R6 m_first", int'(m_first), int'(fq[0]));
      end
      chk(line_err === merr, "R5/R6/R10 line_err", int'(line_err), int'(merr));
      chk(rx_ovf === movf, "R8/R10 rx_ovf", int'(rx_ovf), int'(movf));
    end
  end

  task automatic run(input int n, input int start_den, input bit rnd_ready);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pin_data  = 16'($urandom);
      pin_start = ($urandom_range(start_den - 1) == 0);
      m_ready   = rnd_ready ? ($urandom_range(3) != 0 && $urandom_range(2) != 0) : 1'b1;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(m_valid === 1'b0 && line_err === 1'b0 && rx_ovf === 1'b0, "R1 reset state",
        int'({m_valid, line_err, rx_ovf}), 0);
    rst_n = 1'b1;

    // R9: single word into empty FIFO, visible after second edge
    @(negedge clk);
    cfg_en = 1'b1; cfg_hi_lines = 4'd8; pin_data = 16'hA5C3; pin_start = 1'b1;
    @(negedge clk);
    pin_start = 1'b0;
    chk(m_valid === 1'b0, "R9 not yet valid after one edge", int'(m_valid), 0);
    @(negedge clk);
    chk(m_valid === 1'b1 && m_data === 16'hA5C3 && m_first === 1'b1,
        "R9/R3 word after two edges", int'(m_data), 'hA5C3);

    // R3/R5/R6: active-high marker, len 5, full width
    run(300, 6, 0);
    // R3/R2: inverted marker, three upper lines
    cfg_start_inv = 1'b1; cfg_hi_lines = 4'd3;
    run(300, 6, 0);
    // R10: disable clears counter and sticky flags
    @(negedge clk); cfg_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(line_err === 1'b0 && rx_ovf === 1'b0, "R10 flags cleared", int'({line_err, rx_ovf}), 0);
    // R4: marker ignored, counter-generated starts, no upper lines
    cfg_start_off = 1'b1; cfg_start_inv = 1'b0; cfg_hi_lines = 4'd0; cfg_line_len = 12'd7;
    cfg_en = 1'b1;
    run(300, 2, 0);
    // R8/R7: back-pressure with clamped width and short lines
    cfg_hi_lines = 4'd12; cfg_line_len = 12'd3;
    run(400, 4, 1);
    // R5/R8: marker in use again under back-pressure, length 1 and 0
    cfg_start_off = 1'b0; cfg_line_len = 12'd1;
    run(200, 3, 1);
    cfg_line_len = 12'd0; cfg_hi_lines = 4'd5;
    run(200, 3, 1);
    // R4: re-enable with marker ignored, first word flagged
    @(negedge clk); cfg_en = 1'b0;
    repeat (6) @(negedge clk);
    m_ready = 1'b1;
    cfg_start_off = 1'b1; cfg_line_len = 12'd4; cfg_en = 1'b1;
    run(200, 2, 0);
    @(negedge clk); cfg_en = 1'b0;
    repeat (8) @(negedge clk);
    chk(m_valid === 1'b0, "R7 drained", int'(m_valid), 0);
    done = 1;
    finish_run();
  end
endmodule